// File: doc/BRIEF.md
# Interrupt Status Unit with Read-to-Clear

This block collects the interrupt events of a serial bus controller. Twelve sources feed a raw status word. Ten of them are single-cycle pulses that latch until they are cleared. The other two are levels that track a condition held by the controller. A mask register gates the raw word into a masked status word, and one interrupt line is raised whenever any masked bit is set.

Software works through a small register port. It clears a latched source by reading that source's own clear address. Only that bit drops, so an event that arrives between reading the status and clearing it is never swept away. A combined clear address drops every latched source at once.

A separate sticky register records the reasons behind a transmit abort. It is wiped when the abort source is cleared, so software must read it before clearing the abort.

Top module: `intc_status_unit`

## Requirements
- R1: After reset the raw status, the mask register and the abort-reason register read zero, and irq_o is low.
- R2: The raw status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Every bit except 2 and 4 is set by a one-cycle pulse on evt_i, one cycle later, and stays set until it is cleared. The raw word reads at address 0x01 whatever the mask holds.
- R3: The mask register is written and read at address 0x02 (bits 11:0). The masked status at address 0x00 reads as the raw status AND the mask.
- R4: irq_o is high exactly when some masked status bit is set. A mask of zero holds irq_o low, the raw status is kept, and setting the mask again raises irq_o.
- R5: A read of address 0x10+i returns the current raw bit i in bit 0 and clears only raw bit i.
- R6: A read of address 0x04 clears every latched raw bit and the abort-reason register.
- R7: Bits 2 and 4 equal the evt_i level one cycle earlier, and clear reads have no effect on them.
- R8: An event pulse in the same cycle as a clear read of its bit leaves that bit set.
- R9: The abort-reason register reads at address 0x03. It is the sticky OR of the why_i pulses, with these bit positions: 0 7-bit address no ack, 1 first 10-bit address byte no ack, 2 second 10-bit address byte no ack, 3 data no ack, 4 general call no ack, 5 read after general call, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 master disabled, 12 arbitration lost. Pulses on why_i bits 6 and 8 are ignored.
- R10: The abort-reason register is cleared by a read of the abort clear address 0x16, and by no other per-source clear. A reason pulse in the same cycle as that read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | Event pulses and level conditions, one per source |
| why_i | input | 13 | Abort-reason pulses |
| bus_addr | input | 5 | Register word address |
| bus_rd | input | 1 | Read strobe; a read of a clear address clears that address's bits |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the address presented in the same cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The gating is driven with eight pairs of event pattern and mask. The patterns include all sources firing with an all-zero mask, single isolated bits, alternating bit patterns against mask nibbles, and a set made only of the two level sources. These cases show an AND from an OR, show a dropped or shifted bit lane, and show whether the level sources behave the same way as the latched ones. Directed sequences then clear single bits among several set bits, which shows a per-source clear apart from a clear-all. They also collide a pulse with its own clear in the same cycle. Finally, they run the abort-reason register through ignored bit lanes, clears of unrelated sources and clears of the abort source.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int SRC_N  = 12;
  localparam int WHY_W  = 13;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_MASKED  = 5'h00;
  localparam logic [ADDR_W-1:0] A_RAW     = 5'h01;
  localparam logic [ADDR_W-1:0] A_MASK    = 5'h02;
  localparam logic [ADDR_W-1:0] A_WHY     = 5'h03;
  localparam logic [ADDR_W-1:0] A_CLR_ALL = 5'h04;
  localparam int                CLR_BASE  = 16;

  localparam int SRC_TX_ABORT = 6;
  localparam logic [SRC_N-1:0] LEVEL_SRC = 12'h014;
  localparam logic [WHY_W-1:0] WHY_KEEP  = 13'h1EBF;
endpackage

// File: rtl/intc_bus_decode.sv
`timescale 1ns/1ps
module intc_bus_decode #(
  parameter int SRC_N    = intc_pkg::SRC_N,
  parameter int ADDR_W   = intc_pkg::ADDR_W,
  parameter int CLR_BASE = intc_pkg::CLR_BASE,
  parameter logic [ADDR_W-1:0] CLR_ALL = intc_pkg::A_CLR_ALL,
  parameter logic [ADDR_W-1:0] MASK_AD = intc_pkg::A_MASK
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [SRC_N-1:0]  clr_vec,
  output logic              clr_all,
  output logic              mask_we
);
  assign clr_all = bus_rd && (bus_addr == CLR_ALL);
  assign mask_we = bus_wr && (bus_addr == MASK_AD);

  for (genvar i = 0; i < SRC_N; i++) begin : g_clr
    localparam logic [ADDR_W-1:0] MY_AD = ADDR_W'(CLR_BASE + i);
    assign clr_vec[i] = clr_all || (bus_rd && (bus_addr == MY_AD));
  end
endmodule

// File: rtl/intc_src_bank.sv
`timescale 1ns/1ps
module intc_src_bank #(
  parameter int SRC_N = intc_pkg::SRC_N,
  parameter logic [SRC_N-1:0] LEVEL_MASK = intc_pkg::LEVEL_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] clr,
  output logic [SRC_N-1:0] raw
);
  logic [SRC_N-1:0] raw_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      always_comb raw_d[i] = evt[i];
      logic unused_clr;
      assign unused_clr = clr[i];
    end else begin : g_latch
      // a new event outranks a clear in the same cycle
      always_comb raw_d[i] = evt[i] | (raw[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_d;
  end
endmodule

// File: rtl/intc_abort_reason.sv
`timescale 1ns/1ps
module intc_abort_reason #(
  parameter int WHY_W = intc_pkg::WHY_W,
  parameter logic [WHY_W-1:0] KEEP = intc_pkg::WHY_KEEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WHY_W-1:0] why_in,
  input  logic             clr,
  output logic [WHY_W-1:0] why_q
);
  logic [WHY_W-1:0] why_d;

  always_comb begin
    why_d = clr ? '0 : why_q;
    why_d = why_d | (why_in & KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) why_q <= '0;
    else        why_q <= why_d;
  end
endmodule

// File: rtl/intc_status_unit.sv
`timescale 1ns/1ps
module intc_status_unit #(
  parameter int SRC_N  = intc_pkg::SRC_N,
  parameter int WHY_W  = intc_pkg::WHY_W,
  parameter int DATA_W = intc_pkg::DATA_W,
  parameter int ADDR_W = intc_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic [WHY_W-1:0]  why_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import intc_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [SRC_N-1:0] clr_vec;
  logic             clr_all;
  logic             mask_we;
  logic [SRC_N-1:0] raw_q;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] mask_d;
  logic [SRC_N-1:0] masked;
  logic [WHY_W-1:0] why_q;
  logic             unused_wdata_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  intc_bus_decode #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .clr_vec  (clr_vec),
    .clr_all  (clr_all),
    .mask_we  (mask_we)
  );

  intc_src_bank #(.SRC_N(SRC_N)) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt   (evt_i),
    .clr   (clr_vec),
    .raw   (raw_q)
  );

  intc_abort_reason #(.WHY_W(WHY_W)) u_why (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .why_in (why_i),
    .clr    (clr_vec[SRC_TX_ABORT]),
    .why_q  (why_q)
  );

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SRC_N] ^ clr_all;

  always_comb mask_d = mask_we ? bus_wdata[SRC_N-1:0] : mask_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mask_q <= '0;
    else             mask_q <= mask_d;
  end

  assign masked = raw_q & mask_q;
  assign irq_o  = |masked;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASKED: bus_rdata = DATA_W'(masked);
      A_RAW:    bus_rdata = DATA_W'(raw_q);
      A_MASK:   bus_rdata = DATA_W'(mask_q);
      A_WHY:    bus_rdata = DATA_W'(why_q);
      default: begin
        for (int i = 0; i < SRC_N; i++) begin
          if (bus_addr == ADDR_W'(CLR_BASE + i)) bus_rdata = DATA_W'(raw_q[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/intc_status_unit_chk.sv
`timescale 1ns/1ps
module intc_status_unit_chk #(
  parameter int SRC_N  = intc_pkg::SRC_N,
  parameter int WHY_W  = intc_pkg::WHY_W,
  parameter int ADDR_W = intc_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  evt_i,
  input logic [WHY_W-1:0]  why_i,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SRC_N-1:0]  raw_q,
  input logic [SRC_N-1:0]  mask_q,
  input logic [WHY_W-1:0]  why_q,
  input logic              irq_o
);
  import intc_pkg::*;

  logic abort_clr;
  assign abort_clr = bus_rd && (bus_addr == ADDR_W'(CLR_BASE + SRC_TX_ABORT)
                                || bus_addr == A_CLR_ALL);

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    if (LEVEL_SRC[i]) begin : g_lvl
      // R7
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_q[i] == $past(evt_i[i]));
    end else begin : g_lat
      // R8
      event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> raw_q[i]);
      // R2
      latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[i] && !bus_rd) |=> raw_q[i]);
    end
  end

  // R4
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  // R10
  why_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_clr && why_i == '0) |=> why_q == '0);

  // R9
  why_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_clr |=> (why_q & $past(why_q)) == $past(why_q));
endmodule

bind intc_status_unit intc_status_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .evt_i    (evt_i),
  .why_i    (why_i),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .why_q    (why_q),
  .irq_o    (irq_o)
);

// File: tb/intc_status_unit_bench.sv
`timescale 1ns/1ps
module intc_status_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [11:0] evt_i;
  logic [12:0] why_i;
  logic [4:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_chk;
  int n_bad;
  bit done;

  intc_status_unit u_intc_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .why_i(why_i),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [11:0] LVL = 12'h014;

  // {event pattern, mask, expected masked status}
  localparam logic [35:0] VEC_T [8] = '{
    {12'h001, 12'hFFF, 12'h001},
    {12'h842, 12'h040, 12'h040},
    {12'hFFF, 12'h000, 12'h000},
    {12'h014, 12'h010, 12'h010},
    {12'hA5A, 12'h0F0, 12'h050},
    {12'h5A5, 12'hF0F, 12'h505},
    {12'h800, 12'h7FF, 12'h000},
    {12'h3C3, 12'h381, 12'h381}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_op(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_op(input logic [4:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_evt(input logic [11:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_why(input logic [12:0] w);
    why_i = w;
    @(negedge clk);
    why_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    n_chk = 0; n_bad = 0; done = 1'b0;
    evt_i = '0; why_i = '0; bus_addr = '0; bus_rd = 1'b0;
    bus_wr = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_op(5'h01, d); check("R1 raw", d, 0);
    rd_op(5'h02, d); check("R1 mask", d, 0);
    rd_op(5'h03, d); check("R1 why", d, 0);
    check("R1 irq", irq_o, 0);

    // table walk: R2 R3 R4 R7
    for (int k = 0; k < 8; k++) begin
      logic [11:0] ev, mk, ex;
      {ev, mk, ex} = VEC_T[k];
      evt_i = '0;
      rd_op(5'h04, d);
      wr_op(5'h02, {4'h0, mk});
      evt_i = ev;
      @(negedge clk);
      evt_i = ev & LVL;
      rd_op(5'h01, d); check("R2 raw", d, ev);
      rd_op(5'h00, d); check("R3 masked", d, ex);
      check("R4 irq", irq_o, (ex != 0));
    end
    evt_i = '0;
    rd_op(5'h04, d);
    wr_op(5'h02, 16'h0000);

    // R5 single clear
    pulse_evt(12'h0EB);
    rd_op(5'h01, d); check("R2 latched", d, 12'h0EB);
    rd_op(5'h13, d); check("R5 clear returns bit", d, 1);
    rd_op(5'h01, d); check("R5 only bit3", d, 12'h0E3);
    rd_op(5'h13, d); check("R5 cleared bit", d, 0);

    // R7 level ignores clear
    evt_i = 12'h004;
    @(negedge clk);
    rd_op(5'h12, d); check("R7 level read", d, 1);
    rd_op(5'h01, d); check("R7 level kept", d, 12'h0E7);
    evt_i = '0;
    @(negedge clk);
    rd_op(5'h01, d); check("R7 level drops", d, 12'h0E3);

    // R8 event and clear collide
    pulse_evt(12'h200);
    evt_i = 12'h200; bus_addr = 5'h19; bus_rd = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_rd = 1'b0;
    rd_op(5'h01, d); check("R8 event wins", d, 12'h2E3);

    // R6 clear all
    rd_op(5'h04, d);
    rd_op(5'h01, d); check("R6 all cleared", d, 0);

    // R9 R10 abort reason
    pulse_why(13'h1001);
    rd_op(5'h03, d); check("R9 capture", d, 16'h1001);
    pulse_why(13'h0140);
    rd_op(5'h03, d); check("R9 bits 6 8 ignored", d, 16'h1001);
    pulse_why(13'h0006);
    rd_op(5'h03, d); check("R9 sticky or", d, 16'h1007);
    rd_op(5'h15, d);
    rd_op(5'h03, d); check("R10 other clear", d, 16'h1007);
    rd_op(5'h16, d);
    rd_op(5'h03, d); check("R10 abort clear", d, 0);
    why_i = 13'h0800; bus_addr = 5'h16; bus_rd = 1'b1;
    @(negedge clk);
    why_i = '0; bus_rd = 1'b0;
    rd_op(5'h03, d); check("R10 pulse kept", d, 16'h0800);
    rd_op(5'h04, d);
    rd_op(5'h03, d); check("R6 why cleared", d, 0);

    // R4 mask zero keeps raw
    pulse_evt(12'h200);
    check("R4 irq masked off", irq_o, 0);
    rd_op(5'h01, d); check("R4 raw kept", d, 12'h200);
    wr_op(5'h02, 16'h0200);
    check("R4 irq on", irq_o, 1);
    rd_op(5'h00, d); check("R3 masked", d, 12'h200);
    rd_op(5'h02, d); check("R3 mask readback", d, 12'h200);

    finish_run();
  end
endmodule